// File: doc/BRIEF.md
# Postfix Expression Stack Evaluator

This block evaluates integer arithmetic written in postfix order. Tokens arrive one at a time over a valid/ready handshake. A token is one of four kinds: a signed operand, an arithmetic operator, an end marker, or a reserved code. Operands go onto a small register stack. An operator removes the two topmost entries, combines them and places the single result back on the stack. The end marker reports whatever sits on top as the answer of the expression and then empties the stack, so the next expression can follow at once.

The entry that was on top is the right-hand operand and the entry below it is the left-hand operand. The occupancy count gives the stack pointer: the top item sits at index occupancy-1. Full and empty flags mark the two limits. A sticky error flag collects underflow, overflow and division-by-zero events. That flag, together with a check that the final depth is exactly one, decides the error bit reported with the result.

Top module: `postfix_eval`

## Requirements
- R1: After reset the stack is empty (occupancy 0, empty 1, full 0), tok_ready is 1, err_flag is 0 and res_valid is 0.
- R2: A token of kind 0 (operand) that is accepted while the stack is not full is pushed, and occupancy rises by one. Pushing several operands and then an operator evaluates postfix expressions correctly: 3 4 * 5 6 * + gives 42, and 4 5 * 6 * 2 3 * + 1 + gives 127.
- R3: A token of kind 1 (operator) accepted with at least two entries holds tok_ready low for exactly the two following cycles (remove and compute, then push back). After that, occupancy is one lower than before.
- R4: Operator codes are 0 add, 1 subtract, 2 multiply and 3 divide. The result is left op right, where right is the former top and left the entry beneath it. Results wrap to WIDTH bits, and division truncates toward zero.
- R5: Division by zero sets err_flag and pushes 0.
- R6: An operator accepted with fewer than two entries sets err_flag and leaves the stack unchanged.
- R7: An operand accepted while the stack is full sets err_flag and is dropped: occupancy stays at DEPTH and the top entry is unchanged.
- R8: stack_empty is 1 exactly when occupancy is 0, and stack_full is 1 exactly when occupancy equals DEPTH.
- R9: A token of kind 2 (end) raises res_valid for the single cycle that follows its acceptance. res_value is the top entry (0 if the stack is empty). res_err is err_flag OR (occupancy != 1). In the same step the stack is emptied and err_flag is cleared.
- R10: A token of kind 3 is accepted and has no effect on the stack, err_flag or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Token can be accepted this cycle |
| tok_kind | input | 2 | 0 operand, 1 operator, 2 end, 3 reserved |
| tok_op | input | 2 | 0 add, 1 sub, 2 mul, 3 div (operator tokens) |
| tok_value | input | WIDTH (16) | Signed operand value |
| occupancy | output | CNT_W (4) | Number of stacked entries; top is at occupancy-1 |
| stack_full | output | 1 | Occupancy equals DEPTH |
| stack_empty | output | 1 | Occupancy is zero |
| err_flag | output | 1 | Sticky error for the current expression |
| res_valid | output | 1 | One-cycle result strobe |
| res_value | output | WIDTH (16) | Result of the expression |
| res_err | output | 1 | Result is unreliable |

## Verification
An operand push, a rejected token and an end marker all take effect at the clock edge that accepts them. The bench therefore samples occupancy, err_flag and the result strobe at the falling edge right after that edge, and it checks that res_valid is low again one cycle later. An accepted operator keeps tok_ready low through two falling edges and releases it at the third. The bench samples those three points directly, and for every other operator it waits for tok_ready to return before looking at the stack. A division by zero raises err_flag at the end of the compute cycle, so it is checked only once the operator has finished.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
   typedef enum logic [1:0] {
      TK_NUM  = 2'd0,
      TK_OPR  = 2'd1,
      TK_END  = 2'd2,
      TK_NONE = 2'd3
   } tok_kind_t;

   typedef enum logic [1:0] {
      AR_ADD = 2'd0,
      AR_SUB = 2'd1,
      AR_MUL = 2'd2,
      AR_DIV = 2'd3
   } arith_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EXEC  = 2'd1,
      ST_WRITE = 2'd2
   } phase_t;
endpackage

// File: rtl/pfx_stack.sv
module pfx_stack #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_en,
   input  logic [WIDTH-1:0] push_data,
   input  logic             drop2_en,
   input  logic             clear_en,
   output logic [WIDTH-1:0] top_data,
   output logic [WIDTH-1:0] below_data,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty
);
   logic [WIDTH-1:0] slot [DEPTH];
   logic [IW-1:0]    top_idx;
   logic [IW-1:0]    below_idx;

   assign top_idx   = IW'(count - CW'(1));
   assign below_idx = IW'(count - CW'(2));

   // one register per slot, written only when the push lands on it
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot[g] <= '0;
         else if (push_en && (count == CW'(g)))
            slot[g] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clear_en)
         count <= '0;
      else if (push_en)
         count <= count + CW'(1);
      else if (drop2_en)
         count <= count - CW'(2);
   end

   assign empty      = (count == '0);
   assign full       = (count == CW'(DEPTH));
   assign top_data   = empty ? '0 : slot[top_idx];
   assign below_data = (count < CW'(2)) ? '0 : slot[below_idx];

   assert_no_push_when_full_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !(push_en && full));
   assert_count_bound_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_flags_exclusive_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({full, empty}));
   assert_drop_needs_two_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      drop2_en |-> (count >= CW'(2)));
endmodule

// File: rtl/pfx_alu.sv
module pfx_alu
   import pfx_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] lhs,
   input  logic [WIDTH-1:0] rhs,
   input  arith_t           op,
   output logic [WIDTH-1:0] result,
   output logic             div_zero
);
   always_comb begin
      div_zero = 1'b0;
      unique case (op)
         AR_ADD: result = lhs + rhs;
         AR_SUB: result = lhs - rhs;
         AR_MUL: result = lhs * rhs;
         AR_DIV: begin
            if (rhs == '0) begin
               result   = '0;
               div_zero = 1'b1;
            end else begin
               result = WIDTH'($signed(lhs) / $signed(rhs));
            end
         end
         default: result = '0;
      endcase
   end
endmodule

// File: rtl/pfx_ctrl.sv
module pfx_ctrl
   import pfx_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tok_valid,
   input  logic [1:0]       tok_kind,
   input  logic [1:0]       tok_op,
   input  logic [WIDTH-1:0] tok_value,
   output logic             tok_ready,
   input  logic [CW-1:0]    count,
   input  logic             full,
   input  logic [WIDTH-1:0] top_data,
   input  logic [WIDTH-1:0] alu_result,
   input  logic             alu_div_zero,
   output arith_t           alu_op,
   output logic             push_en,
   output logic [WIDTH-1:0] push_data,
   output logic             drop2_en,
   output logic             clear_en,
   output logic             err_flag,
   output logic             res_valid,
   output logic [WIDTH-1:0] res_value,
   output logic             res_err
);
   phase_t           phase;
   arith_t           op_q;
   logic [WIDTH-1:0] hold_q;
   logic             take;
   tok_kind_t        kind;
   logic             bad_push;
   logic             bad_pop;
   logic             start_op;

   assign kind      = tok_kind_t'(tok_kind);
   assign tok_ready = (phase == ST_IDLE);
   assign take      = tok_valid && tok_ready;
   assign bad_push  = take && (kind == TK_NUM) && full;
   assign bad_pop   = take && (kind == TK_OPR) && (count < CW'(2));
   assign start_op  = take && (kind == TK_OPR) && (count >= CW'(2));
   assign alu_op    = op_q;

   always_comb begin
      push_en   = 1'b0;
      push_data = tok_value;
      drop2_en  = 1'b0;
      clear_en  = 1'b0;
      if (phase == ST_WRITE) begin
         push_en   = 1'b1;
         push_data = hold_q;
      end else if (phase == ST_EXEC) begin
         drop2_en = 1'b1;
      end else if (take) begin
         push_en  = (kind == TK_NUM) && !full;
         clear_en = (kind == TK_END);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= ST_IDLE;
         op_q   <= AR_ADD;
         hold_q <= '0;
      end else begin
         unique case (phase)
            ST_IDLE: if (start_op) begin
               phase <= ST_EXEC;
               op_q  <= arith_t'(tok_op);
            end
            ST_EXEC: begin
               phase  <= ST_WRITE;
               hold_q <= alu_result;
            end
            ST_WRITE: phase <= ST_IDLE;
            default:  phase <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_flag  <= 1'b0;
         res_valid <= 1'b0;
         res_value <= '0;
         res_err   <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         if (take && (kind == TK_END)) begin
            res_valid <= 1'b1;
            res_value <= top_data;
            res_err   <= err_flag || (count != CW'(1));
            err_flag  <= 1'b0;
         end else if (bad_push || bad_pop || ((phase == ST_EXEC) && alu_div_zero)) begin
            err_flag <= 1'b1;
         end
      end
   end

   assert_exec_then_write_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_EXEC) |=> (phase == ST_WRITE));
   assert_divzero_flags_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == ST_EXEC) && alu_div_zero) |=> err_flag);
endmodule

// File: rtl/postfix_eval.sv
module postfix_eval
   import pfx_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int DEPTH = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tok_valid,
   output logic             tok_ready,
   input  logic [1:0]       tok_kind,
   input  logic [1:0]       tok_op,
   input  logic [WIDTH-1:0] tok_value,
   output logic [CNT_W-1:0] occupancy,
   output logic             stack_full,
   output logic             stack_empty,
   output logic             err_flag,
   output logic             res_valid,
   output logic [WIDTH-1:0] res_value,
   output logic             res_err
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("postfix_eval: DEPTH must be at least 2");
   end
   if (WIDTH < 2) begin : g_bad_width
      $error("postfix_eval: WIDTH must be at least 2");
   end

   logic             push_en;
   logic [WIDTH-1:0] push_data;
   logic             drop2_en;
   logic             clear_en;
   logic [WIDTH-1:0] top_data;
   logic [WIDTH-1:0] below_data;
   logic [WIDTH-1:0] alu_result;
   logic             alu_div_zero;
   arith_t           alu_op;

   pfx_stack #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_en    (push_en),
      .push_data  (push_data),
      .drop2_en   (drop2_en),
      .clear_en   (clear_en),
      .top_data   (top_data),
      .below_data (below_data),
      .count      (occupancy),
      .full       (stack_full),
      .empty      (stack_empty)
   );

   pfx_alu #(.WIDTH(WIDTH)) i_alu (
      .lhs      (below_data),
      .rhs      (top_data),
      .op       (alu_op),
      .result   (alu_result),
      .div_zero (alu_div_zero)
   );

   pfx_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .tok_valid    (tok_valid),
      .tok_kind     (tok_kind),
      .tok_op       (tok_op),
      .tok_value    (tok_value),
      .tok_ready    (tok_ready),
      .count        (occupancy),
      .full         (stack_full),
      .top_data     (top_data),
      .alu_result   (alu_result),
      .alu_div_zero (alu_div_zero),
      .alu_op       (alu_op),
      .push_en      (push_en),
      .push_data    (push_data),
      .drop2_en     (drop2_en),
      .clear_en     (clear_en),
      .err_flag     (err_flag),
      .res_valid    (res_valid),
      .res_value    (res_value),
      .res_err      (res_err)
   );

   assert_op_stalls_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_ready && tok_kind == 2'd1 && occupancy >= CNT_W'(2))
      |=> !tok_ready ##1 !tok_ready ##1 tok_ready);
   assert_underflow_ignored_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_ready && tok_kind == 2'd1 && occupancy < CNT_W'(2))
      |=> ($stable(occupancy) && err_flag));
   assert_overflow_ignored_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_ready && tok_kind == 2'd0 && stack_full)
      |=> (stack_full && err_flag));
   assert_result_clears_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (occupancy == '0 && !err_flag));
   assert_err_sticky_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !(tok_valid && tok_ready && tok_kind == 2'd2)) |=> err_flag);
endmodule

// File: tb/test_postfix_eval.sv
module test_postfix_eval;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tok_valid = 1'b0;
   logic        tok_ready;
   logic [1:0]  tok_kind = 2'd0;
   logic [1:0]  tok_op = 2'd0;
   logic [15:0] tok_value = '0;
   logic [3:0]  occupancy;
   logic        stack_full, stack_empty, err_flag, res_valid, res_err;
   logic [15:0] res_value;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   postfix_eval i_postfix_eval (
      .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
      .tok_kind(tok_kind), .tok_op(tok_op), .tok_value(tok_value),
      .occupancy(occupancy), .stack_full(stack_full), .stack_empty(stack_empty),
      .err_flag(err_flag), .res_valid(res_valid), .res_value(res_value),
      .res_err(res_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] k, input logic [1:0] o, input logic [15:0] v);
      @(negedge clk);
      tok_valid = 1'b1; tok_kind = k; tok_op = o; tok_value = v;
      while (!tok_ready) @(negedge clk);
      @(posedge clk);
      #1 tok_valid = 1'b0;
   endtask

   task automatic num(input logic [15:0] v);
      send(2'd0, 2'd0, v);
   endtask

   task automatic opr(input logic [1:0] o);
      send(2'd1, o, 16'd0);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!tok_ready) @(negedge clk);
   endtask

   task automatic finish_expr(input string tag, input logic [15:0] val, input logic err);
      send(2'd2, 2'd0, 16'd0);
      @(negedge clk);
      chk({tag, " R9 strobe"}, res_valid, 1);
      chk({tag, " R9 value"}, res_value, val);
      chk({tag, " R9 err"}, res_err, err);
      chk({tag, " R9 cleared"}, occupancy, 0);
      chk({tag, " R9 flag cleared"}, err_flag, 0);
      @(negedge clk);
      chk({tag, " R9 one cycle"}, res_valid, 0);
   endtask

   task automatic t_reset();
      chk("R1 occupancy", occupancy, 0);
      chk("R1 empty", stack_empty, 1);
      chk("R1 full", stack_full, 0);
      chk("R1 ready", tok_ready, 1);
      chk("R1 err", err_flag, 0);
      chk("R1 res_valid", res_valid, 0);
   endtask

   task automatic t_expr42();
      num(16'd3); num(16'd4);
      chk("R2 push count", occupancy, 2);
      chk("R8 not empty", stack_empty, 0);
      opr(2'd2);
      @(negedge clk); chk("R3 stall 1", tok_ready, 0);
      @(negedge clk); chk("R3 stall 2", tok_ready, 0);
      @(negedge clk); chk("R3 release", tok_ready, 1);
      chk("R3 depth after op", occupancy, 1);
      num(16'd5); num(16'd6); opr(2'd2); opr(2'd0);
      finish_expr("R2 expr42", 16'd42, 0);
   endtask

   task automatic t_expr127();
      num(16'd4); num(16'd5); opr(2'd2); num(16'd6); opr(2'd2);
      num(16'd2); num(16'd3); opr(2'd2); opr(2'd0); num(16'd1); opr(2'd0);
      finish_expr("R2 expr127", 16'd127, 0);
   endtask

   task automatic t_arith();
      num(16'd10); num(16'd3); opr(2'd1);
      finish_expr("R4 sub order", 16'd7, 0);
      num(16'hFFF9); num(16'd2); opr(2'd3);
      finish_expr("R4 div trunc", 16'hFFFD, 0);
      num(16'd300); num(16'd300); opr(2'd2);
      finish_expr("R4 mul wrap", 16'd24464, 0);
      num(16'h7FFF); num(16'd1); opr(2'd0);
      finish_expr("R4 add wrap", 16'h8000, 0);
      num(16'd3); num(16'd20); opr(2'd3);
      finish_expr("R4 div small", 16'd0, 0);
   endtask

   task automatic t_divzero();
      num(16'd5); num(16'd0); opr(2'd3);
      wait_idle();
      chk("R5 err", err_flag, 1);
      chk("R5 depth", occupancy, 1);
      finish_expr("R5 result", 16'd0, 1);
   endtask

   task automatic t_underflow();
      num(16'd5); opr(2'd0);
      @(negedge clk);
      chk("R6 err", err_flag, 1);
      chk("R6 depth", occupancy, 1);
      chk("R6 ready", tok_ready, 1);
      finish_expr("R6 top kept", 16'd5, 1);
      opr(2'd1);
      @(negedge clk);
      chk("R6 empty err", err_flag, 1);
      chk("R6 empty depth", occupancy, 0);
      finish_expr("R6 empty result", 16'd0, 1);
   endtask

   task automatic t_overflow();
      for (int i = 1; i <= 8; i++) num(16'(i));
      chk("R8 full", stack_full, 1);
      chk("R8 full depth", occupancy, 8);
      num(16'd99);
      @(negedge clk);
      chk("R7 err", err_flag, 1);
      chk("R7 depth", occupancy, 8);
      chk("R7 full kept", stack_full, 1);
      finish_expr("R7 top kept", 16'd8, 1);
      chk("R8 empty after", stack_empty, 1);
   endtask

   task automatic t_depth_two();
      num(16'd1); num(16'd2);
      finish_expr("R9 depth two", 16'd2, 1);
   endtask

   task automatic t_reserved();
      num(16'd4);
      send(2'd3, 2'd2, 16'd9);
      @(negedge clk);
      chk("R10 depth", occupancy, 1);
      chk("R10 err", err_flag, 0);
      chk("R10 no result", res_valid, 0);
      finish_expr("R10 result", 16'd4, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_expr42();
      t_expr127();
      t_arith();
      t_divzero();
      t_underflow();
      t_overflow();
      t_depth_two();
      t_reserved();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         vectors++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule